// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a processor's register file and a 32-bit external data bus whose lanes are ordered big-endian: the byte at offset 0 inside a word travels on bus bits 31:24 and the byte at offset 3 on bits 7:0. For stores it turns register data into a bus word plus per-lane write strobes. A byte store copies the low register byte onto every lane and enables only the lane the address selects. A word store passes the register through unchanged and enables all lanes.

For loads it takes the word read from the bus and forms the value written back to the register. A byte load picks the addressed lane and zero-extends it. A word load at a misaligned address does not fault and is not split into two accesses. Instead the bus word is rotated right by eight bits for each byte of offset. When a configuration input enables it, a misaligned word access raises an alignment-fault output, and a faulting store has its write strobes withdrawn. The load result is registered and appears one cycle after read data is presented, together with a result-valid pulse.

Operation codes on `req_op`: `00` word load, `01` byte load, `10` word store, `11` byte store. `req_addr[1:0]` is the byte offset inside the word.

Top module: `be_lsu_aligner`

## Requirements
- R1: For an accepted byte store with offset k, `bus_wstrb` is one-hot with only bit 3-k set. Offset 0 enables bit 3, which is lane D[31:24], and offset 3 enables bit 0, which is lane D[7:0].
- R2: For an accepted byte store, each of the four byte lanes of `bus_wdata` carries `req_wdata[7:0]`.
- R3: For an accepted word store that does not fault, `bus_wdata` equals `req_wdata` bit for bit (register bit 31 on D[31]), and `bus_wstrb` is 4'b1111.
- R4: When `req_valid` is low, or the operation is a load, `bus_wstrb` is 4'b0000 and `bus_wdata` is zero.
- R5: A word load rotates the bus word right by 8 times the offset. With bus bytes AA,BB,CC,DD at offsets 0..3, offsets 0, 1, 2 and 3 give AABBCCDD, DDAABBCC, CCDDAABB and BBCCDDAA. At offsets 0 and 2 the addressed byte ends up in bits 31:24, and at offsets 1 and 3 it ends up in bits 15:8.
- R6: A byte load returns the addressed lane in bits 7:0 with bits 31:8 zero. With the same bus word, offsets 0..3 give 000000AA, 000000BB, 000000CC and 000000DD.
- R7: `res_valid` is high exactly in the cycle after a cycle in which `rd_valid` was high. `res_data` then holds the load result for the `req_op` and `req_addr` present with `rd_valid`, and keeps its value in cycles without `rd_valid`.
- R8: `align_fault` is high exactly when `req_valid`, `cfg_align_fault_en`, a word operation (`00` or `10`) and a non-zero offset occur together. Byte operations never fault.
- R9: A word store that raises `align_fault` drives `bus_wstrb` to 4'b0000.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `res_valid` is 0 and `res_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_align_fault_en | input | 1 | Enables misaligned word-access fault detection |
| req_valid | input | 1 | Store/request qualifier for the current cycle |
| req_op | input | 2 | Operation code: 00 word load, 01 byte load, 10 word store, 11 byte store |
| req_addr | input | 32 | Byte address; bits 1:0 are the lane offset |
| req_wdata | input | 32 | Register data for stores |
| bus_wdata | output | 32 | Store data driven onto the big-endian bus |
| bus_wstrb | output | 4 | Per-lane write enables, bit 3 = D[31:24] |
| align_fault | output | 1 | Misaligned word access flagged |
| rd_valid | input | 1 | Read data from the bus is valid this cycle |
| rd_data | input | 32 | Read data from the bus |
| res_valid | output | 1 | Registered load result is valid |
| res_data | output | 32 | Registered load result for the register file |

## Verification
A wrong lane index in the store path shows up on `bus_wstrb` or `bus_wdata` in the same cycle as the request, because that path has no registers. Picking the wrong byte or the wrong rotation amount in the load path shows up on `res_data` exactly one cycle after `rd_valid`, and only for the offsets affected. That is why every offset is driven with a known byte pattern as well as with random data. A fault on the result register's capture enable shows either as a `res_valid` pulse in the wrong cycle or as `res_data` drifting between loads, and both are visible on the next cycle.

// File: rtl/be_lsu_pkg.sv
// Package: shared operation codes for the big-endian load/store aligner.
// Assumes the two-bit operation code of the top module's port list.
package be_lsu_pkg;

    typedef enum logic [1:0] {
        OP_LD_WORD = 2'b00,
        OP_LD_BYTE = 2'b01,
        OP_ST_WORD = 2'b10,
        OP_ST_BYTE = 2'b11
    } lsu_op_e;

    // Bit 1 of the code separates stores from loads, bit 0 byte from word.
    function automatic logic op_is_store(input lsu_op_e op);
        return op[1];
    endfunction

    function automatic logic op_is_byte(input lsu_op_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/be_align_check.sv
// Module: be_align_check
// Raises a fault for a word access whose byte offset is not zero, when
// checking is enabled. Byte accesses are never flagged.
// Assumes offset is the low address bits inside one bus word.
module be_align_check #(
    parameter int OFF_W = 2
) (
    input  logic             chk_en,
    input  logic             access_valid,
    input  logic             access_is_word,
    input  logic [OFF_W-1:0] offset,
    output logic             fault
);

    // Purpose: combine the enable, the access qualifier and the offset test.
    always_comb begin
        fault = chk_en && access_valid && access_is_word && (offset != '0);
    end

endmodule

// File: rtl/be_store_lanes.sv
// Module: be_store_lanes
// Builds the store bus word and the per-lane write enables for a
// big-endian bus: lane index LANES-1 carries address offset 0.
// Assumes LANES is a power of two and each lane is 8 bits wide.
module be_store_lanes #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              store_en,
    input  logic              is_byte,
    input  logic              suppress,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] src_data,
    output logic [DATA_W-1:0] bus_data,
    output logic [LANES-1:0]  lane_strb
);

    logic drive_en;

    // Purpose: the bus is driven only for an accepted store.
    always_comb begin
        drive_en = store_en;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(LANES - 1 - g);
        logic lane_hit;
        logic [7:0] lane_byte;

        // Purpose: decide whether this lane matches the byte offset.
        always_comb begin
            lane_hit = (offset == LANE_OFF);
        end

        // Purpose: pick the replicated low byte or this lane's own byte.
        always_comb begin
            if (!drive_en) begin
                lane_byte = 8'h00;
            end else if (is_byte) begin
                lane_byte = src_data[7:0];
            end else begin
                lane_byte = src_data[8*g +: 8];
            end
        end

        assign bus_data[8*g +: 8] = lane_byte;
        assign lane_strb[g] = drive_en && !suppress && (!is_byte || lane_hit);
    end

endmodule

// File: rtl/be_load_rotator.sv
// Module: be_load_rotator
// Forms the register write-back value from a big-endian bus word: a word
// load rotates right by one lane per byte of offset, and a byte load
// zero-extends the addressed lane.
// Assumes LANES is a power of two so offset arithmetic wraps naturally.
module be_load_rotator #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              is_byte,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] bus_word,
    output logic [DATA_W-1:0] result
);

    logic [7:0]       rd_lane [LANES];
    logic [OFF_W-1:0] byte_src;
    logic [7:0]       picked;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign rd_lane[g] = bus_word[8*g +: 8];
    end

    // Purpose: find the lane that holds the addressed byte.
    always_comb begin
        byte_src = OFF_W'(LANES - 1) - offset;
        picked   = rd_lane[byte_src];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_out
        logic [OFF_W-1:0] rot_src;
        logic [7:0]       out_byte;

        // Purpose: lane g of a rotated word comes from lane g+offset.
        always_comb begin
            rot_src = OFF_W'(g) + offset;
            if (is_byte) begin
                out_byte = (g == 0) ? picked : 8'h00;
            end else begin
                out_byte = rd_lane[rot_src];
            end
        end

        assign result[8*g +: 8] = out_byte;
    end

endmodule

// File: rtl/be_lsu_aligner.sv
// Module: be_lsu_aligner (top)
// Aligns data between a register file and a big-endian 32-bit bus: the
// store path is combinational, the load result is registered one cycle
// after rd_valid. Optional fault on misaligned word accesses.
// Assumes req_op/req_addr describe the load in the cycle rd_valid is high.
module be_lsu_aligner #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_align_fault_en,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W/8-1:0] bus_wstrb,
    output logic              align_fault,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);

    import be_lsu_pkg::*;

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    lsu_op_e          op;
    logic [OFF_W-1:0] offset;
    logic             is_store;
    logic             is_byte;
    logic             store_en;
    logic             unused_addr;
    logic [DATA_W-1:0] load_value;

    // Purpose: decode the operation code and the lane offset.
    always_comb begin
        op          = lsu_op_e'(req_op);
        offset      = req_addr[OFF_W-1:0];
        is_store    = op_is_store(op);
        is_byte     = op_is_byte(op);
        store_en    = req_valid && is_store;
        unused_addr = ^req_addr[ADDR_W-1:OFF_W];
    end

    be_align_check #(
        .OFF_W(OFF_W)
    ) u_align (
        .chk_en         (cfg_align_fault_en),
        .access_valid   (req_valid),
        .access_is_word (!is_byte),
        .offset         (offset),
        .fault          (align_fault)
    );

    be_store_lanes #(
        .DATA_W(DATA_W),
        .LANES (LANES),
        .OFF_W (OFF_W)
    ) u_store (
        .store_en  (store_en),
        .is_byte   (is_byte),
        .suppress  (align_fault),
        .offset    (offset),
        .src_data  (req_wdata),
        .bus_data  (bus_wdata),
        .lane_strb (bus_wstrb)
    );

    be_load_rotator #(
        .DATA_W(DATA_W),
        .LANES (LANES),
        .OFF_W (OFF_W)
    ) u_load (
        .is_byte  (is_byte),
        .offset   (offset),
        .bus_word (rd_data),
        .result   (load_value)
    );

    // Purpose: register the load result and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= rd_valid;
            if (rd_valid) begin
                res_data <= load_value;
            end
        end
    end

endmodule

// File: rtl/be_lsu_aligner_chk.sv
// Module: be_lsu_aligner_chk
// Port-level properties of the aligner, bound into every instance.
module be_lsu_aligner_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_align_fault_en,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W/8-1:0] bus_wstrb,
    input logic              align_fault,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data
);

    // R1
    byte_strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |-> $countones(bus_wstrb) == 1);

    // R2
    byte_replicate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |-> bus_wdata == {(DATA_W/8){req_wdata[7:0]}});

    // R3
    word_store_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && !align_fault) |-> (bus_wdata == req_wdata && &bus_wstrb));

    // R4
    no_load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_op[1]) |-> (bus_wstrb == '0 && bus_wdata == '0));

    // R5
    aligned_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && req_op == 2'b00 && req_addr[1:0] == 2'b00) |=> res_data == $past(rd_data));

    // R7
    result_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> res_valid);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!res_valid && $stable(res_data)));

    // R8
    fault_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_align_fault_en |-> !align_fault);

    // R9
    fault_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> bus_wstrb == '0);

endmodule

bind be_lsu_aligner be_lsu_aligner_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/be_lsu_aligner_tb.sv
`timescale 1ns/1ps
module be_lsu_aligner_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_wstrb;
    logic        align_fault;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic        exp_rv = 1'b0;
    logic [31:0] exp_rd = '0;

    always #2 clk = ~clk;

    be_lsu_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_align_fault_en(cfg_en),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
        .align_fault(align_fault), .rd_valid(rd_valid), .rd_data(rd_data),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Memory byte k of the bus word (k=0 on bits 31:24).
    function automatic logic [7:0] mem_byte(input logic [31:0] w, input int k);
        return w[31 - 8*k -: 8];
    endfunction

    function automatic logic [31:0] model_load(input logic [1:0] op, input logic [1:0] off,
                                               input logic [31:0] w);
        logic [31:0] r = '0;
        if (op == 2'b01) begin
            r[7:0] = mem_byte(w, off);
        end else begin
            for (int j = 0; j < 4; j++) begin
                r[31 - 8*j -: 8] = mem_byte(w, (j - off + 4) % 4);
            end
        end
        return r;
    endfunction

    function automatic logic model_fault(input logic v, input logic en, input logic [1:0] op,
                                         input logic [1:0] off);
        return v && en && (op[0] == 1'b0) && (off != 2'b00);
    endfunction

    function automatic logic [3:0] model_strb(input logic v, input logic en, input logic [1:0] op,
                                              input logic [1:0] off);
        if (!v || !op[1] || model_fault(v, en, op, off)) return 4'b0000;
        if (op == 2'b10) return 4'b1111;
        return 4'b1000 >> off;
    endfunction

    function automatic logic [31:0] model_wdata(input logic v, input logic [1:0] op,
                                                input logic [31:0] d);
        if (!v || !op[1]) return 32'h0;
        if (op == 2'b11) return {4{d[7:0]}};
        return d;
    endfunction

    // One cycle: check registered outputs, drive, check combinational ones.
    task automatic step(input logic v, input logic en, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] wd,
                        input logic rv, input logic [31:0] rd);
        @(negedge clk);
        check("R7 res_valid", {31'b0, res_valid}, {31'b0, exp_rv});
        check("R5/R6/R7 res_data", res_data, exp_rd);
        req_valid = v; cfg_en = en; req_op = op; req_addr = a;
        req_wdata = wd; rd_valid = rv; rd_data = rd;
        #1;
        check("R8 align_fault", {31'b0, align_fault}, {31'b0, model_fault(v, en, op, a[1:0])});
        check("R1/R3/R4/R9 bus_wstrb", {28'b0, bus_wstrb}, {28'b0, model_strb(v, en, op, a[1:0])});
        check("R2/R3/R4 bus_wdata", bus_wdata, model_wdata(v, op, wd));
        exp_rv = rv;
        if (rv) exp_rd = model_load(op, a[1:0], rd);
    endtask

    initial begin
        #400000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 res_valid", {31'b0, res_valid}, 32'h0);
        check("R10 res_data", res_data, 32'h0);
        rst_n = 1'b1;

        // R5 word loads at every offset
        for (int k = 0; k < 4; k++) step(1, 0, 2'b00, 32'h1000 + k, 0, 1, 32'hAABBCCDD);
        // R6 byte loads at every offset
        for (int k = 0; k < 4; k++) step(1, 0, 2'b01, 32'h1000 + k, 0, 1, 32'hAABBCCDD);
        // R7 hold across idle cycles
        step(0, 0, 2'b00, 0, 0, 0, 32'h12345678);
        step(0, 0, 2'b00, 0, 0, 0, 32'h87654321);
        // R3 word store, R1/R2 byte stores
        step(1, 0, 2'b10, 32'h1000, 32'h76543210, 0, 0);
        for (int k = 0; k < 4; k++) step(1, 1, 2'b11, 32'h1004 + k, k + 1, 0, 0);
        // R8/R9 misaligned word store and load with fault enabled
        step(1, 1, 2'b10, 32'h1002, 32'hDEADBEEF, 0, 0);
        step(1, 1, 2'b00, 32'h1003, 0, 1, 32'h11223344);
        step(1, 0, 2'b10, 32'h1001, 32'hCAFEF00D, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [1:0] op = 2'($urandom);
            logic v = ($urandom % 8) != 0;
            logic rv = !op[1] && (($urandom % 2) == 1);
            step(v, 1'($urandom), op, $urandom, $urandom, rv, $urandom);
        end
        step(0, 0, 2'b00, 0, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule